// File: doc/BRIEF.md
# Flip-Aware Scanline Interrupt Generator

This block turns a stream of line-start strobes into a periodic CPU interrupt level and a vertical-blank flag. It keeps a physical line counter of 8 bits that advances by one on each strobe and wraps after 256 lines. From that counter it derives an effective vertical position. In normal orientation the effective position equals the line number. When the screen is flipped, the vertical count runs backwards, so the effective position is 256 minus the line number, taken modulo 256.

The interrupt is a level, and software does not acknowledge it. Every 32 lines the interrupt takes the inverse of bit 5 of the effective position. The lines on which it updates are those whose bit 4 equals the flip state and whose low four bits are zero. Flipping the screen therefore moves every interrupt edge by 16 lines. The flip control is captured only on a line strobe, so a change never lands in the middle of a line.

Top module: `scanline_irq_gen`

## Requirements
- R1: While reset is asserted and until the first strobe after it, the effective position is 0, vblank is 1, the interrupt is 0 and flip is treated as off.
- R2: Each cycle with `line_stb` high advances the line counter by one, and the counter wraps from 255 to 0. In cycles without a strobe the effective position does not change.
- R3: The effective position `veff_o` equals the line counter when flip is off. When flip is on it equals (256 − line counter) mod 256.
- R4: `flip_i` is sampled only in a cycle with `line_stb` high. In any other cycle its value has no effect on the outputs.
- R5: An update point is a line whose new effective position has bits [3:0] equal to 0 and bit 4 equal to the flip state. At an update point the interrupt becomes the inverse of bit 5 of that position.
- R6: With flip off, the interrupt is set at effective positions 0, 64, 128 and 192, and cleared at 32, 96, 160 and 224.
- R7: With flip on, the interrupt is set at effective positions 16, 80, 144 and 208, and cleared at 48, 112, 176 and 240.
- R8: `vblank_o` is 1 exactly when the effective position is below 24.
- R9: The interrupt keeps its value on every line that is not an update point and in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle line-start strobe |
| flip_i | input | 1 | Screen-flip request, captured on a strobe |
| irq_o | output | 1 | Interrupt level |
| vblank_o | output | 1 | Effective position below 24 |
| veff_o | output | 8 | Effective vertical position |

## Verification
On a single strobe the block can move the line counter, pick up a new flip value and update the interrupt all at once. The case that matters is a strobe that changes the flip state and also lands on an update point under the new orientation. The bench provokes this by switching flip every few dozen lines at several phases. For each strobe it judges the interrupt against an update-point test made on the new effective position with the newly sampled flip value. During the idle cycles between strobes the bench toggles `flip_i` and expects every output to stay where it was.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  localparam int unsigned LINE_W     = 8;   // physical line counter width
  localparam int unsigned IRQ_BIT    = 5;   // bit giving the interrupt level
  localparam int unsigned PHASE_BIT  = 4;   // bit compared with flip
  localparam int unsigned VBLANK_END = 24;  // first line outside vblank

  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/sirq_line_ctr.sv
module sirq_line_ctr
  import scanline_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_stb,
  input  logic  flip_i,
  output line_t scan_q,
  output logic  flip_q,
  output line_t scan_nx,
  output logic  flip_nx
);
  always_comb begin
    scan_nx = scan_q;
    flip_nx = flip_q;
    if (line_stb) begin
      scan_nx = scan_q + line_t'(1);
      flip_nx = flip_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
      flip_q <= 1'b0;
    end else if (line_stb) begin
      scan_q <= scan_nx;
      flip_q <= flip_nx;
    end
  end

  // R2
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb |=> (scan_q == line_t'($past(scan_q) + line_t'(1))));

  // R4
  flip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> ($stable(flip_q) && $stable(scan_q)));
endmodule

// File: rtl/sirq_vmap.sv
module sirq_vmap
  import scanline_irq_pkg::*;
(
  input  line_t scan,
  input  logic  flip,
  output line_t veff,
  output logic  vblank,
  output logic  at_point
);
  always_comb begin
    veff     = flip ? (line_t'(0) - scan) : scan;
    vblank   = (veff < line_t'(VBLANK_END));
    at_point = (veff[PHASE_BIT-1:0] == '0) && (veff[PHASE_BIT] == flip);
  end
endmodule

// File: rtl/sirq_irq_latch.sv
module sirq_irq_latch
  import scanline_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_stb,
  input  logic  at_point_nx,
  input  line_t veff_nx,
  output logic  irq_q
);
  logic irq_nx;
  logic irq_en;

  always_comb begin
    irq_en = line_stb && at_point_nx;
    irq_nx = ~veff_nx[IRQ_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_nx;
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !at_point_nx) |=> $stable(irq_q));
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import scanline_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              flip_i,
  output logic              irq_o,
  output logic              vblank_o,
  output logic [LINE_W-1:0] veff_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  line_t scan_q, scan_nx, veff_nx;
  logic  flip_q, flip_nx, at_point_q, at_point_nx, vblank_nx;

  sirq_line_ctr u_ctr (
    .clk(clk), .rst_n(rst_int_n), .line_stb(line_stb), .flip_i(flip_i),
    .scan_q(scan_q), .flip_q(flip_q), .scan_nx(scan_nx), .flip_nx(flip_nx)
  );

  sirq_vmap u_map_cur (
    .scan(scan_q), .flip(flip_q),
    .veff(veff_o), .vblank(vblank_o), .at_point(at_point_q)
  );

  sirq_vmap u_map_nx (
    .scan(scan_nx), .flip(flip_nx),
    .veff(veff_nx), .vblank(vblank_nx), .at_point(at_point_nx)
  );

  sirq_irq_latch u_irq (
    .clk(clk), .rst_n(rst_int_n), .line_stb(line_stb),
    .at_point_nx(at_point_nx), .veff_nx(veff_nx), .irq_q(irq_o)
  );

  // R5
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(irq_o) |-> at_point_q);

  // R6
  irq_set_noflip_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_stb ##1 (!flip_q && veff_o[IRQ_BIT:0] == '0)) |-> irq_o);

  // R7
  irq_set_flip_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_stb ##1 (flip_q && veff_o[IRQ_BIT:0] == (IRQ_BIT+1)'(16))) |-> irq_o);

  // R8
  vblank_rise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(vblank_o) && !$stable(flip_q)) or !$rose(vblank_o) or
    (veff_o == '0) or (veff_o == line_t'(VBLANK_END-1)));
endmodule

// File: tb/scanline_irq_gen_test.sv
module scanline_irq_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_stb;
  logic       flip_i;
  logic       irq_o;
  logic       vblank_o;
  logic [7:0] veff_o;

  always #2 clk = ~clk; // 250 MHz

  scanline_irq_gen uut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .flip_i(flip_i),
    .irq_o(irq_o), .vblank_o(vblank_o), .veff_o(veff_o)
  );

  typedef struct packed {
    logic [7:0] v;
    logic       vb;
    logic       irq;
    logic       idle;
    logic       upd;
    logic       fl;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // bench model
  int m_scan = 0;
  bit m_flip = 0;
  bit m_irq  = 0;

  function automatic int eff(int s, bit f);
    return f ? ((256 - s) & 255) : s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(bit idle, bit upd);
    exp_t e;
    int v;
    v = eff(m_scan, m_flip);
    e.v = 8'(v); e.vb = (v < 24); e.irq = m_irq;
    e.idle = idle; e.upd = upd; e.fl = m_flip;
    q.push_back(e);
  endtask

  // driver: one strobe, then idle cycles with flip_i toggled (R4)
  task automatic line(bit f, int gap);
    int v;
    bit upd;
    @(negedge clk);
    line_stb = 1'b1; flip_i = f;
    @(posedge clk);
    #1;
    m_scan = (m_scan + 1) & 255;
    m_flip = f;
    v = eff(m_scan, m_flip);
    // R5: update when low bits zero and bit 4 matches flip
    upd = ((v & 15) == 0) && (((v >> 4) & 1) == m_flip);
    if (upd) m_irq = (((v >> 5) & 1) == 0);
    push(0, upd);
    @(negedge clk);
    line_stb = 1'b0;
    for (int i = 0; i < gap; i++) begin
      flip_i = ~f;
      @(posedge clk);
      #1;
      push(1, 0);
      @(negedge clk);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string tv, ti;
      e = q.pop_front();
      tv = e.idle ? "R4" : "R3";
      chk(veff_o == e.v, tv, veff_o, e.v);
      chk(vblank_o == e.vb, "R8", vblank_o, e.vb);
      if (e.upd) ti = e.fl ? "R7" : "R6";
      else       ti = "R9";
      chk(irq_o == e.irq, ti, irq_o, e.irq);
    end
  end

  initial begin
    rst_n = 1'b0; line_stb = 1'b0; flip_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state, flip_i high is not taken in
    chk(veff_o == 0, "R1", veff_o, 0);
    chk(vblank_o == 1, "R1", vblank_o, 1);
    chk(irq_o == 0, "R1", irq_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(veff_o == 0 && irq_o == 0 && vblank_o == 1, "R1", {irq_o, veff_o}, 0);
    // R2: wrap over more than one frame, normal orientation
    for (int i = 0; i < 300; i++) line(1'b0, (i % 5 == 0) ? 2 : 0);
    // flipped frames
    for (int i = 0; i < 300; i++) line(1'b1, (i % 7 == 0) ? 1 : 0);
    // flip changes at many phases, including onto update points
    for (int i = 0; i < 1200; i++) line(1'b0 ^ bit'((i / 37) & 1), (i % 11 == 0) ? 1 : 0);
    for (int i = 0; i < 600; i++) line(bit'((i / 16) & 1), 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule